// File: doc/BRIEF.md
# DDR2 Open-Row Command Scheduler

This block turns single-byte read and write requests, presented on a flat 24-bit address bus, into the command stream of a x4 DDR2 device whose initialization has already completed. A request is announced by a falling edge on an active-low bus select. The write-enable line chooses the direction, and the address is split into bank, row and column. Each access moves one byte as the first two nibbles of a length-4 burst, low nibble first. A ready flag reports when the latest access has finished, and a read result is then presented on a byte-wide output.

When nothing is pending, the scheduler issues refresh commands continuously, each as soon as the previous refresh period has ended. The first access after a refresh starts an open-row timer. Until the timer runs out, accesses to the open bank and row go straight to a column command. An access to another bank or row costs a precharge and an activate, and the timer keeps running through it. When the timer has expired and the current access is complete, the bank is precharged and refreshing resumes. All timing values are parameters counted in command-clock cycles.

Top module: `ddr2_openrow_sched`

## Requirements
- R1: While reset is asserted, ready is 1, all four command pins are 1 and the data output enable is 0. A high device select always comes with ras, cas and we all high.
- R2: Command encodings on {cs, ras, cas, we} are ACT 0011, READ 0101, WRITE 0100, PRECHARGE 0010 and REFRESH 0001. With no request pending, REFRESH is issued repeatedly, exactly T_RFC cycles apart.
- R3: A request is recognised only on a high-to-low transition of the bus select. Ready is 0 in the cycle after that edge, and a select held low starts exactly one access.
- R4: The address is decoded as bank = bits 23:22, row = bits 21:9 and column = bits 8:0. ACT drives the row on the address pins. A column command drives the column on pins 8:0 with pins 12:9 low, so pin 10 is low and no auto-precharge occurs. Both commands carry the bank on the bank pins.
- R5: A write drives the data byte as two nibbles with the output enable high: the low nibble CL-1 cycles after WRITE and the high nibble in the next cycle. A read captures nibbles CL and CL+1 cycles after READ, low nibble first. The byte appears on the read output when ready rises.
- R6: A column command follows its ACT by exactly T_RCD cycles. The command after a PRECHARGE follows it by exactly T_RP cycles.
- R7: While the timer runs, an access to the open bank and row issues only a column command. Ready is 1 at CL+3 cycles after the select falls for a write, and at CL+4 cycles for a read.
- R8: An access to a different bank or row precharges the open bank and then activates the new one. A read of this kind is ready T_RP+T_RCD+CL+4 cycles after the select falls.
- R9: The open-row timer starts at the ACT that leaves the refresh loop and is not restarted by a row change. With no further activity, the closing PRECHARGE comes exactly OPEN_CYC cycles after that ACT. REFRESH is issued only when no row is open.
- R10: A request arriving during a refresh is held. Its ACT follows that REFRESH by exactly T_RFC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Flat-bus select; a falling edge starts an access |
| bus_we_n | input | 1 | Flat-bus direction: 0 write, 1 read |
| bus_addr | input | 24 | Flat byte address |
| bus_wdata | input | 8 | Write byte |
| bus_ready | output | 1 | Latest access complete |
| bus_rdata | output | 8 | Read byte |
| mem_cs_n | output | 1 | Device select |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Device write enable |
| mem_ba | output | 2 | Bank address |
| mem_a | output | 13 | Multiplexed row/column address |
| mem_dq_o | output | 4 | Write nibble |
| mem_dq_oe | output | 1 | Write nibble drive enable |
| mem_dq_i | input | 4 | Read nibble |

## Verification
The bench builds the block with T_RCD = 2, T_RP = 3, T_RFC = 5, CL = 3 and OPEN_CYC = 48. Because T_RP and T_RCD differ, exact gap checks detect a swapped counter. The short refresh period means requests regularly land in the middle of a refresh. The timeout is long enough for an access out of the refresh loop followed by a row change, so the closing precharge can be timed to the cycle. It is also short enough that the 72-access sweep over every bank, three row values and three column values often sees the timer expire while a request is pending.

// File: rtl/ddr2_openrow_sched.sv
module ddr2_openrow_sched #(
  parameter int AW       = 24,
  parameter int BW       = 2,
  parameter int RW       = 13,
  parameter int CW       = 9,
  parameter int MAW      = 13,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RFC    = 6,
  parameter int CL       = 3,
  parameter int OPEN_CYC = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_cs_n,
  input  logic           bus_we_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic           bus_ready,
  output logic [7:0]     bus_rdata,
  output logic           mem_cs_n,
  output logic           mem_ras_n,
  output logic           mem_cas_n,
  output logic           mem_we_n,
  output logic [BW-1:0]  mem_ba,
  output logic [MAW-1:0] mem_a,
  output logic [3:0]     mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [3:0]     mem_dq_i
);
  localparam int WL   = CL - 1;
  localparam int M1   = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int M2   = (M1 > T_RCD) ? M1 : T_RCD;
  localparam int CMAX = (M2 > CL + 2) ? M2 : CL + 2;
  localparam int CNTW = $clog2(CMAX + 1);
  localparam int TW   = $clog2(OPEN_CYC);

  localparam logic [CNTW-1:0] K_RCD = CNTW'(T_RCD - 1);
  localparam logic [CNTW-1:0] K_RP  = CNTW'(T_RP - 1);
  localparam logic [CNTW-1:0] K_RFC = CNTW'(T_RFC - 1);
  localparam logic [CNTW-1:0] K_WL0 = CNTW'(WL - 1);
  localparam logic [CNTW-1:0] K_WL  = CNTW'(WL);
  localparam logic [CNTW-1:0] K_WL1 = CNTW'(WL + 1);
  localparam logic [CNTW-1:0] K_CL  = CNTW'(CL);
  localparam logic [CNTW-1:0] K_CL1 = CNTW'(CL + 1);
  localparam logic [TW-1:0]   K_TMR = TW'(OPEN_CYC - 1);

  localparam logic [3:0] C_NOP = 4'b1111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  typedef enum logic [2:0] {S_IDLE, S_REFW, S_RCD, S_DATA, S_OPEN, S_RP} st_t;

  st_t            st, n_st;
  logic [CNTW-1:0] cnt, n_cnt;
  logic [TW-1:0]  tmr;
  logic [3:0]     cmd_q, n_cmd, dq_q, lo_nib;
  logic [BW-1:0]  r_ba, o_ba, ba_q;
  logic [RW-1:0]  r_row, o_row;
  logic [CW-1:0]  r_col;
  logic [MAW-1:0] a_q, col_a;
  logic [7:0]     r_wd, rdat;
  logic           cs_q, pend, r_wr, row_open, to_idle, oe_q, rdy;
  logic           do_act, do_col, do_pre, ld_tmr, pre_idle, dat_done;
  logic           fall, hit, expired, idle_dec;
  logic [CNTW-1:0] last_k;

  assign fall     = cs_q & ~bus_cs_n;
  assign hit      = row_open && (r_ba == o_ba) && (r_row == o_row);
  assign expired  = (tmr == '0);
  assign idle_dec = (st == S_IDLE) || (st == S_REFW && cnt == '0) ||
                    (st == S_RP && to_idle && cnt == '0);
  assign last_k   = r_wr ? K_WL1 : K_CL1;
  assign col_a    = MAW'(r_col) & ~(MAW'(1) << 10);

  always_comb begin
    n_st     = st;
    n_cnt    = (cnt == '0) ? cnt : cnt - CNTW'(1);
    n_cmd    = C_NOP;
    do_act   = 1'b0;
    do_col   = 1'b0;
    do_pre   = 1'b0;
    ld_tmr   = 1'b0;
    pre_idle = 1'b0;
    dat_done = 1'b0;
    if (idle_dec) begin
      if (pend) begin
        n_cmd = C_ACT; do_act = 1'b1; ld_tmr = 1'b1; n_st = S_RCD; n_cnt = K_RCD;
      end else begin
        n_cmd = C_REF; n_st = S_REFW; n_cnt = K_RFC;
      end
    end else begin
      case (st)
        S_RP: if (cnt == '0) begin
          n_cmd = C_ACT; do_act = 1'b1; n_st = S_RCD; n_cnt = K_RCD;
        end
        S_RCD: if (cnt == '0) begin
          n_cmd = r_wr ? C_WR : C_RD; do_col = 1'b1; n_st = S_DATA; n_cnt = '0;
        end
        S_DATA: begin
          n_cnt = cnt + CNTW'(1);
          if (cnt == last_k) begin
            dat_done = 1'b1; n_st = S_OPEN;
          end
        end
        S_OPEN: begin
          if (expired) begin
            n_cmd = C_PRE; do_pre = 1'b1; pre_idle = 1'b1; n_st = S_RP; n_cnt = K_RP;
          end else if (pend) begin
            if (hit) begin
              n_cmd = r_wr ? C_WR : C_RD; do_col = 1'b1; n_st = S_DATA; n_cnt = '0;
            end else begin
              n_cmd = C_PRE; do_pre = 1'b1; n_st = S_RP; n_cnt = K_RP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmr <= '0; cmd_q <= C_NOP;
      ba_q <= '0; a_q <= '0; dq_q <= '0; oe_q <= 1'b0; lo_nib <= '0;
      cs_q <= 1'b1; pend <= 1'b0; r_wr <= 1'b0; r_ba <= '0; r_row <= '0;
      r_col <= '0; r_wd <= '0; o_ba <= '0; o_row <= '0; row_open <= 1'b0;
      to_idle <= 1'b0; rdy <= 1'b1; rdat <= '0;
    end else begin
      st    <= n_st;
      cnt   <= n_cnt;
      cmd_q <= n_cmd;
      cs_q  <= bus_cs_n;
      if (ld_tmr)        tmr <= K_TMR;
      else if (!expired) tmr <= tmr - TW'(1);
      if (do_act) begin
        ba_q <= r_ba; a_q <= MAW'(r_row);
        row_open <= 1'b1; o_ba <= r_ba; o_row <= r_row;
      end
      if (do_col) begin
        ba_q <= r_ba; a_q <= col_a; pend <= 1'b0;
      end
      if (do_pre) begin
        ba_q <= o_ba; a_q <= '0; row_open <= 1'b0; to_idle <= pre_idle;
      end
      if (n_cmd == C_REF) a_q <= '0;
      if (st == S_DATA) begin
        if (r_wr) begin
          if (cnt == K_WL0) begin dq_q <= r_wd[3:0]; oe_q <= 1'b1; end
          if (cnt == K_WL)  dq_q <= r_wd[7:4];
          if (cnt == K_WL1) oe_q <= 1'b0;
        end else begin
          if (cnt == K_CL)  lo_nib <= mem_dq_i;
          if (cnt == K_CL1) rdat <= {mem_dq_i, lo_nib};
        end
      end
      if (dat_done) rdy <= 1'b1;
      if (fall) begin
        pend  <= 1'b1;
        rdy   <= 1'b0;
        r_wr  <= ~bus_we_n;
        r_ba  <= bus_addr[AW-1 -: BW];
        r_row <= bus_addr[CW +: RW];
        r_col <= bus_addr[CW-1:0];
        r_wd  <= bus_wdata;
      end
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_ba    = ba_q;
  assign mem_a     = a_q;
  assign mem_dq_o  = dq_q;
  assign mem_dq_oe = oe_q;
  assign bus_ready = rdy;
  assign bus_rdata = rdat;
endmodule

// File: rtl/ddr2_openrow_sched_chk.sv
module ddr2_openrow_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_cs_n,
  input logic bus_ready,
  input logic mem_cs_n,
  input logic mem_ras_n,
  input logic mem_cas_n,
  input logic mem_we_n,
  input logic a10,
  input logic mem_dq_oe,
  input logic row_open
);
  a_r1_deselect_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_ras_n && mem_cas_n && mem_we_n));

  a_r3_ready_drops_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_cs_n) && !bus_cs_n) |=> !bus_ready);

  a_r4_col_no_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && mem_ras_n && !mem_cas_n) |-> !a10);

  a_r5_burst_starts_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |=> mem_dq_oe);

  a_r5_burst_ends_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_dq_oe) && mem_dq_oe) |=> !mem_dq_oe);

  a_r9_refresh_rows_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n) |-> !row_open);
endmodule

bind ddr2_openrow_sched ddr2_openrow_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ready(bus_ready),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .a10(mem_a[10]), .mem_dq_oe(mem_dq_oe),
  .row_open(row_open)
);

// File: tb/ddr2_openrow_sched_test.sv
module ddr2_openrow_sched_test;
  localparam int P_RCD = 2, P_RP = 3, P_RFC = 5, P_CL = 3, P_OPEN = 48;
  localparam int P_WL = P_CL - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1;
  logic [23:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready;
  logic [7:0] rdata;
  logic m_cs, m_ras, m_cas, m_we, dq_oe;
  logic [1:0] ba;
  logic [12:0] a;
  logic [3:0] dq_o, dq_i = '0;

  always #10 clk = ~clk;

  ddr2_openrow_sched #(.T_RCD(P_RCD), .T_RP(P_RP), .T_RFC(P_RFC), .CL(P_CL),
    .OPEN_CYC(P_OPEN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_addr(addr),
    .bus_wdata(wdata), .bus_ready(ready), .bus_rdata(rdata), .mem_cs_n(m_cs),
    .mem_ras_n(m_ras), .mem_cas_n(m_cas), .mem_we_n(m_we), .mem_ba(ba), .mem_a(a),
    .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i));

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural device model, evaluated mid-cycle
  logic [7:0] mem [int];
  int ncyc = 0, prev = 15;
  int last_act = -1000, last_pre = -1000, last_ref = -1000;
  int sess_act = -1000, exp_pre = -1000;
  int wr_cyc = -1000, rd_cyc = -1000, wkey = 0, rkey = 0;
  int col_count = 0, ref_count = 0, ref_act = 0;
  bit m_open = 0;
  logic [1:0] m_ba = '0;
  logic [12:0] m_row = '0;
  logic [1:0] c_ba = '0;
  logic [12:0] c_row = '0;
  logic [8:0] c_col = '0;
  logic [3:0] wlo = '0;

  always @(negedge clk) begin
    int cmd;
    ncyc++;
    cmd = {m_cs, m_ras, m_cas, m_we};
    if (rst_n && cmd != 15) begin
      case (cmd)
        4'b0011: begin
          chk(!m_open, "R8 activate with row open", m_open, 0);
          if (prev == 4'b0010) chk(ncyc - last_pre == P_RP, "R6 PRE to ACT", ncyc - last_pre, P_RP);
          if (prev == 4'b0001) begin
            chk(ncyc - last_ref == P_RFC, "R10 REF to ACT", ncyc - last_ref, P_RFC);
            sess_act = ncyc; ref_act++;
          end
          m_open = 1; m_ba = ba; m_row = a; last_act = ncyc;
        end
        4'b0101, 4'b0100: begin
          chk(m_open && ba == m_ba, "R4 column bank", int'(ba), int'(m_ba));
          chk(a[12:9] == 0, "R4 column high pins", int'(a[12:9]), 0);
          if (prev == 4'b0011) chk(ncyc - last_act == P_RCD, "R6 ACT to column", ncyc - last_act, P_RCD);
          col_count++; c_ba = ba; c_row = m_row; c_col = a[8:0];
          if (cmd == 4'b0100) begin wr_cyc = ncyc; wkey = {ba, m_row, a[8:0]}; end
          else begin rd_cyc = ncyc; rkey = {ba, m_row, a[8:0]}; end
        end
        4'b0010: begin
          chk(m_open && ba == m_ba, "R8 precharge bank", int'(ba), int'(m_ba));
          m_open = 0; last_pre = ncyc;
        end
        4'b0001: begin
          chk(!m_open, "R9 refresh with row open", m_open, 0);
          if (prev == 4'b0001) chk(ncyc - last_ref == P_RFC, "R2 REF spacing", ncyc - last_ref, P_RFC);
          if (prev == 4'b0010) begin
            chk(ncyc - last_pre == P_RP, "R6 PRE to REF", ncyc - last_pre, P_RP);
            exp_pre = last_pre;
          end
          last_ref = ncyc; ref_count++;
        end
        default: chk(0, "R2 illegal command", cmd, 15);
      endcase
      prev = cmd;
    end
    if (ncyc == wr_cyc + P_WL) begin
      chk(dq_oe == 1, "R5 low nibble enable", dq_oe, 1); wlo = dq_o;
    end
    if (ncyc == wr_cyc + P_WL + 1) begin
      chk(dq_oe == 1, "R5 high nibble enable", dq_oe, 1); mem[wkey] = {dq_o, wlo};
    end
    if (ncyc == rd_cyc + P_CL)     dq_i = mem.exists(rkey) ? mem[rkey][3:0] : 4'h0;
    if (ncyc == rd_cyc + P_CL + 1) dq_i = mem.exists(rkey) ? mem[rkey][7:4] : 4'h0;
  end

  task automatic do_acc(input bit wr, input logic [23:0] ad, input logic [7:0] wd,
                        input int hold, output int lat, output logic [7:0] rd);
    cs_n = 1'b0; we_n = ~wr; addr = ad; wdata = wd; lat = 0;
    do begin @(negedge clk); lat++; end while (!ready && lat < 1000);
    rd = rdata;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [23:0] sw_addr(input int i);
    logic [12:0] r;
    logic [8:0] c;
    r = ((i / 3) % 3 == 0) ? 13'd0 : ((i / 3) % 3 == 1) ? 13'd1 : 13'h1FFF;
    c = (i % 3 == 0) ? 9'd0 : (i % 3 == 1) ? 9'd1 : 9'h1FF;
    return {2'(i / 9), r, c};
  endfunction

  function automatic logic [7:0] sw_data(input int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic fields(input logic [23:0] ad);
    chk({c_ba, c_row, c_col} == ad, "R4 address split", int'({c_ba, c_row, c_col}), int'(ad));
  endtask

  initial begin
    int lat, c0;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk(ready == 1, "R1 reset ready", ready, 1);
    chk({m_cs, m_ras, m_cas, m_we} == 4'hF, "R1 reset command pins", {m_cs, m_ras, m_cas, m_we}, 15);
    chk(dq_oe == 0, "R1 reset output enable", dq_oe, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(ref_count >= 4, "R2 refresh while idle", ref_count, 4);

    for (int i = 0; i < 36; i++) begin
      do_acc(1, sw_addr(i), sw_data(i), 0, lat, rd);
      fields(sw_addr(i));
    end
    for (int i = 35; i >= 0; i--) begin
      do_acc(0, sw_addr(i), 8'h00, 0, lat, rd);
      chk(rd == sw_data(i), "R5 read data", rd, sw_data(i));
      fields(sw_addr(i));
    end
    chk(ref_act > 0, "R10 request served after refresh", ref_act, 1);

    repeat (80) @(negedge clk);
    do_acc(1, {2'd0, 13'd3, 9'd5}, 8'hA5, 0, lat, rd);
    do_acc(1, {2'd0, 13'd3, 9'd6}, 8'h3C, 0, lat, rd);
    chk(lat == P_CL + 3, "R7 hit write latency", lat, P_CL + 3);
    do_acc(0, {2'd0, 13'd3, 9'd5}, 8'h00, 0, lat, rd);
    chk(lat == P_CL + 4, "R7 hit read latency", lat, P_CL + 4);
    chk(rd == 8'hA5, "R7 hit read data", rd, 8'hA5);
    do_acc(0, sw_addr(20), 8'h00, 0, lat, rd);
    chk(lat == P_RP + P_RCD + P_CL + 4, "R8 miss read latency", lat, P_RP + P_RCD + P_CL + 4);
    chk(rd == sw_data(20), "R8 miss read data", rd, sw_data(20));

    repeat (80) @(negedge clk);
    c0 = col_count;
    do_acc(0, sw_addr(4), 8'h00, 20, lat, rd);
    chk(col_count - c0 == 1, "R3 held select one access", col_count - c0, 1);
    chk(rd == sw_data(4), "R3 held select data", rd, sw_data(4));

    repeat (80) @(negedge clk);
    do_acc(0, {2'd1, 13'd5, 9'd2}, 8'h00, 0, lat, rd);
    do_acc(0, {2'd2, 13'd7, 9'd3}, 8'h00, 0, lat, rd);
    repeat (80) @(negedge clk);
    chk(exp_pre - sess_act == P_OPEN, "R9 timer not restarted", exp_pre - sess_act, P_OPEN);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule